// File: doc/BRIEF.md
# Packet Timestamp Capture Bank

This block holds hardware timestamps for timing-protocol frames until software collects them. It watches a free-running 64-bit nanosecond time value. When an already qualified capture strobe arrives from the transmit or receive path, the block freezes that time into a holding slot. There is one transmit slot and four receive slots.

A receive capture goes into the lowest-numbered slot that is free. The number of that slot comes back in the same cycle, so the datapath can attach it to the frame's descriptor. Software later uses that number to read the right timestamp.

A slot keeps its value until software reads its upper word, and that read frees the slot. A transmit capture can raise an interrupt, which a separate enable input gates. A clear strobe empties every slot at once. It also clears the sticky receive overflow flag and the pending interrupt.

Top module: `tsl_bank`

## Requirements
- R1: After reset every slot is free, the status word reads 0 and `irq_o` is low.
- R2: A receive strobe is accepted when any receive slot is free. In the same cycle `rx_ok_o` is high and `rx_slot_o` names the lowest-numbered free slot. That slot stores `time_ns_i` as sampled at the clock edge that ends the cycle.
- R3: A receive strobe that arrives while all four receive slots are held is dropped, and `rx_ok_o` stays low. It sets the overflow flag (status bit 5), which stays set until a clear.
- R4: A held slot is never overwritten. Receive allocation skips it, and a transmit strobe that arrives while the transmit slot is held is dropped.
- R5: A read of a slot's upper word frees that slot: select 3 for transmit, select 9+2k for receive slot k. A read of a lower word (select 2, or 8+2k) leaves the slot held.
- R6: If the upper word of a slot is read in the same cycle that a capture targets it, the read returns the old value. The slot is then freed, and the new capture is taken in that same cycle.
- R7: A transmit capture taken while `tx_irq_en_i` is high drives `irq_o` high from the next cycle. It stays high until the transmit upper word is read or a clear occurs. A transmit capture taken with the enable low leaves `irq_o` low.
- R8: `clear_i` frees all five slots and clears both the overflow flag and `irq_o` at the next edge. Any capture strobe in that same cycle is dropped, and `rx_ok_o` stays low.
- R9: Reads are registered. `rd_data_o` shows the selected word in the cycle after `rd_en_i` and keeps it until the next read. Select 0 returns status: bits 3:0 are the receive held flags, bit 4 is transmit held, bit 5 is overflow and bit 6 is the interrupt pending flag. Lower words are time bits 31:0, and upper words are bits 63:32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_ns_i | input | 64 | Current time in nanoseconds |
| rx_cap_i | input | 1 | Receive capture strobe, already qualified |
| rx_ok_o | output | 1 | Receive capture accepted this cycle |
| rx_slot_o | output | 2 | Slot index used by the receive capture |
| tx_cap_i | input | 1 | Transmit capture strobe, already qualified |
| tx_irq_en_i | input | 1 | Transmit interrupt enable |
| clear_i | input | 1 | Free all slots, clear overflow and interrupt |
| rd_en_i | input | 1 | Read strobe |
| rd_sel_i | input | 4 | Read select: 0 status, 2/3 transmit low/high, 8+2k/9+2k receive slot k low/high |
| rd_data_o | output | 32 | Registered read data |
| irq_o | output | 1 | Transmit timestamp interrupt |

## Verification
`rx_ok_o` and `rx_slot_o` are combinational, so the bench checks them one time step after it drives the strobe, before the edge. Held flags, overflow, `irq_o` and `rd_data_o` all change at the edge that ends the stimulus cycle. The bench drives on the falling edge and checks those results at the next falling edge, exactly one register stage later. Same-cycle cases put the read and the capture in one driven cycle. They then confirm the outcome with a separate read, whose data is due one cycle after that read.

// File: rtl/tsl_pkg.sv
package tsl_pkg;
  // read select codes; receive slot k uses RX_BASE+2k (low) and RX_BASE+2k+1 (high)
  localparam int SEL_STATUS  = 0;
  localparam int SEL_TX_LO   = 2;
  localparam int SEL_TX_HI   = 3;
  localparam int SEL_RX_BASE = 8;
endpackage

// File: rtl/tsl_slot.sv
// One holding register with a held flag; release is applied before capture.
module tsl_slot #(
  parameter int TS_W = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cap_i,
  input  logic            rel_i,
  input  logic            clr_i,
  input  logic [TS_W-1:0] time_i,
  output logic            full_o,
  output logic [TS_W-1:0] val_o
);
  logic full_q, full_d;
  logic load;
  logic [TS_W-1:0] val_q;

  always_comb begin
    load   = cap_i && !clr_i;
    full_d = full_q;
    if (clr_i)      full_d = 1'b0;
    else if (cap_i) full_d = 1'b1;
    else if (rel_i) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    val_q <= '0;
    else if (load) val_q <= time_i;
  end

  assign full_o = full_q;
  assign val_o  = val_q;
endmodule

// File: rtl/tsl_pick.sv
// Lowest-index free slot finder.
module tsl_pick #(
  parameter int N     = 4,
  parameter int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     free_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int k = N - 1; k >= 0; k--) begin
      if (free_i[k]) begin
        idx_o = IDX_W'(k);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tsl_bank.sv
module tsl_bank
  import tsl_pkg::*;
#(
  parameter  int TS_W   = 64,
  parameter  int N_RX   = 4,
  localparam int WORD_W = TS_W / 2,
  localparam int IDX_W  = (N_RX > 1) ? $clog2(N_RX) : 1,
  localparam int SEL_W  = $clog2(SEL_RX_BASE + 2 * N_RX)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TS_W-1:0]   time_ns_i,
  input  logic              rx_cap_i,
  output logic              rx_ok_o,
  output logic [IDX_W-1:0]  rx_slot_o,
  input  logic              tx_cap_i,
  input  logic              tx_irq_en_i,
  input  logic              clear_i,
  input  logic              rd_en_i,
  input  logic [SEL_W-1:0]  rd_sel_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              irq_o
);
  logic [N_RX-1:0]  rx_full, rx_rel, rx_free, rx_cap_vec;
  logic [TS_W-1:0]  rx_val [N_RX];
  logic [IDX_W-1:0] pick_idx;
  logic             pick_any, rx_take;
  logic             tx_full, tx_rel, tx_take;
  logic [TS_W-1:0]  tx_val;
  logic             ovf_q, ovf_d, irq_q, irq_d;
  logic [WORD_W-1:0] rd_q, rd_d;

  // upper-word reads release, applied before any capture in the same cycle
  assign tx_rel  = rd_en_i && (rd_sel_i == SEL_W'(SEL_TX_HI));
  assign rx_free = ~rx_full | rx_rel;

  tsl_pick #(.N(N_RX), .IDX_W(IDX_W)) u_pick (
    .free_i (rx_free),
    .idx_o  (pick_idx),
    .any_o  (pick_any)
  );

  assign rx_take   = rx_cap_i && pick_any && !clear_i;
  assign tx_take   = tx_cap_i && (!tx_full || tx_rel) && !clear_i;
  assign rx_ok_o   = rx_take;
  assign rx_slot_o = pick_idx;

  for (genvar k = 0; k < N_RX; k++) begin : g_rx
    assign rx_rel[k]     = rd_en_i && (rd_sel_i == SEL_W'(SEL_RX_BASE + 2 * k + 1));
    assign rx_cap_vec[k] = rx_take && (pick_idx == IDX_W'(k));
    tsl_slot #(.TS_W(TS_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .cap_i  (rx_cap_vec[k]),
      .rel_i  (rx_rel[k]),
      .clr_i  (clear_i),
      .time_i (time_ns_i),
      .full_o (rx_full[k]),
      .val_o  (rx_val[k])
    );
  end

  tsl_slot #(.TS_W(TS_W)) u_tx (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_i  (tx_take),
    .rel_i  (tx_rel),
    .clr_i  (clear_i),
    .time_i (time_ns_i),
    .full_o (tx_full),
    .val_o  (tx_val)
  );

  // sticky overflow and interrupt pending
  always_comb begin
    ovf_d = ovf_q;
    irq_d = irq_q;
    if (clear_i) begin
      ovf_d = 1'b0;
      irq_d = 1'b0;
    end else begin
      if (rx_cap_i && !pick_any)  ovf_d = 1'b1;
      if (tx_take && tx_irq_en_i) irq_d = 1'b1;
      else if (tx_rel)            irq_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
      irq_q <= irq_d;
    end
  end

  // read mux
  always_comb begin
    rd_d = '0;
    if (rd_sel_i == SEL_W'(SEL_STATUS))
      rd_d = WORD_W'({irq_q, ovf_q, tx_full, rx_full});
    else if (rd_sel_i == SEL_W'(SEL_TX_LO))
      rd_d = tx_val[WORD_W-1:0];
    else if (rd_sel_i == SEL_W'(SEL_TX_HI))
      rd_d = tx_val[TS_W-1:WORD_W];
    for (int k = 0; k < N_RX; k++) begin
      if (rd_sel_i == SEL_W'(SEL_RX_BASE + 2 * k))
        rd_d = rx_val[k][WORD_W-1:0];
      if (rd_sel_i == SEL_W'(SEL_RX_BASE + 2 * k + 1))
        rd_d = rx_val[k][TS_W-1:WORD_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_d;
  end

  assign rd_data_o = rd_q;
  assign irq_o     = irq_q;
endmodule

// File: rtl/tsl_bank_chk.sv
module tsl_bank_chk #(
  parameter int N_RX  = 4,
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_cap_i,
  input logic             tx_cap_i,
  input logic             clear_i,
  input logic             rx_ok_o,
  input logic [IDX_W-1:0] rx_slot_o,
  input logic             irq_o,
  input logic             tx_rel,
  input logic [N_RX-1:0]  rx_full,
  input logic             tx_full,
  input logic             ovf
);
  assert_rx_slot_held_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ok_o |=> rx_full[$past(rx_slot_o)]);

  assert_ovf_on_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_cap_i && !rx_ok_o && !clear_i) |=> ovf);

  assert_ovf_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !clear_i) |=> ovf);

  assert_tx_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_rel && !tx_cap_i && !clear_i) |=> !tx_full);

  assert_irq_needs_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> tx_full);

  assert_clear_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (rx_full == '0) && !tx_full && !ovf && !irq_o);
endmodule

bind tsl_bank tsl_bank_chk #(.N_RX(N_RX), .IDX_W(IDX_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rx_cap_i  (rx_cap_i),
  .tx_cap_i  (tx_cap_i),
  .clear_i   (clear_i),
  .rx_ok_o   (rx_ok_o),
  .rx_slot_o (rx_slot_o),
  .irq_o     (irq_o),
  .tx_rel    (tx_rel),
  .rx_full   (rx_full),
  .tx_full   (tx_full),
  .ovf       (ovf_q)
);

// File: tb/tsl_bank_test.sv
module tsl_bank_test;
  logic        clk;
  logic        rst_n;
  logic [63:0] time_ns;
  logic        rx_cap, tx_cap, irq_en, clr, rd_en;
  logic [3:0]  rd_sel;
  logic        rx_ok, irq;
  logic [1:0]  rx_slot;
  logic [31:0] rd_data;
  int checks = 0;
  int fails  = 0;

  tsl_bank uut (
    .clk         (clk),
    .rst_n       (rst_n),
    .time_ns_i   (time_ns),
    .rx_cap_i    (rx_cap),
    .rx_ok_o     (rx_ok),
    .rx_slot_o   (rx_slot),
    .tx_cap_i    (tx_cap),
    .tx_irq_en_i (irq_en),
    .clear_i     (clr),
    .rd_en_i     (rd_en),
    .rd_sel_i    (rd_sel),
    .rd_data_o   (rd_data),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  typedef struct packed {
    logic        rxc;
    logic        txc;
    logic        rde;
    logic [3:0]  sel;
    logic [15:0] tim;
    logic        eok;
    logic [1:0]  eslot;
    logic        eirq;
    logic [31:0] edata;
  } vec_t;

  // rx slot k: low select 8+2k, high 9+2k; status: [3:0] rx, 4 tx, 5 ovf, 6 irq
  localparam vec_t VEC [19] = '{
    '{1'b1, 1'b0, 1'b0, 4'd0,  16'd1, 1'b1, 2'd0, 1'b0, 32'h0},
    '{1'b1, 1'b0, 1'b0, 4'd0,  16'd2, 1'b1, 2'd1, 1'b0, 32'h0},
    '{1'b0, 1'b0, 1'b1, 4'd0,  16'd0, 1'b0, 2'd0, 1'b0, 32'h0000_0003},
    '{1'b0, 1'b0, 1'b1, 4'd8,  16'd0, 1'b0, 2'd0, 1'b0, 32'h5A5A_0001},
    '{1'b0, 1'b0, 1'b1, 4'd9,  16'd0, 1'b0, 2'd0, 1'b0, 32'hC0DE_0001},
    '{1'b1, 1'b0, 1'b0, 4'd0,  16'd3, 1'b1, 2'd0, 1'b0, 32'h0},
    '{1'b1, 1'b0, 1'b0, 4'd0,  16'd4, 1'b1, 2'd2, 1'b0, 32'h0},
    '{1'b1, 1'b0, 1'b0, 4'd0,  16'd5, 1'b1, 2'd3, 1'b0, 32'h0},
    '{1'b1, 1'b0, 1'b0, 4'd0,  16'd6, 1'b0, 2'd0, 1'b0, 32'h0},
    '{1'b0, 1'b0, 1'b1, 4'd0,  16'd0, 1'b0, 2'd0, 1'b0, 32'h0000_002F},
    '{1'b0, 1'b0, 1'b1, 4'd14, 16'd0, 1'b0, 2'd0, 1'b0, 32'h5A5A_0005},
    '{1'b1, 1'b0, 1'b1, 4'd11, 16'd7, 1'b1, 2'd1, 1'b0, 32'hC0DE_0002},
    '{1'b0, 1'b0, 1'b1, 4'd10, 16'd0, 1'b0, 2'd0, 1'b0, 32'h5A5A_0007},
    '{1'b0, 1'b1, 1'b0, 4'd0,  16'd8, 1'b0, 2'd0, 1'b1, 32'h0},
    '{1'b0, 1'b1, 1'b0, 4'd0,  16'd9, 1'b0, 2'd0, 1'b1, 32'h0},
    '{1'b0, 1'b0, 1'b1, 4'd0,  16'd0, 1'b0, 2'd0, 1'b1, 32'h0000_007F},
    '{1'b0, 1'b0, 1'b1, 4'd2,  16'd0, 1'b0, 2'd0, 1'b1, 32'h5A5A_0008},
    '{1'b0, 1'b0, 1'b1, 4'd3,  16'd0, 1'b0, 2'd0, 1'b0, 32'hC0DE_0008},
    '{1'b0, 1'b0, 1'b1, 4'd0,  16'd0, 1'b0, 2'd0, 1'b0, 32'h0000_002F}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(logic rxc, logic txc, logic rde, logic [3:0] sel,
                       logic [15:0] tim, logic c);
    rx_cap  = rxc;
    tx_cap  = txc;
    rd_en   = rde;
    rd_sel  = sel;
    clr     = c;
    time_ns = {16'hC0DE, tim, 16'h5A5A, tim};
  endtask

  task automatic idle();
    drive(1'b0, 1'b0, 1'b0, 4'd0, 16'd0, 1'b0);
  endtask

  task automatic read_word(logic [3:0] sel, output logic [31:0] d);
    drive(1'b0, 1'b0, 1'b1, sel, 16'd0, 1'b0);
    @(negedge clk);
    d = rd_data;
    idle();
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n  = 1'b0;
    irq_en = 1'b1;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 irq", 64'(irq), 64'd0);
    check("R1 rx_ok idle", 64'(rx_ok), 64'd0);
    read_word(4'd0, d);
    check("R1 status", 64'(d), 64'd0);

    // table walk: R2 allocation, R9 read data, R7 interrupt
    for (int i = 0; i < 19; i++) begin
      drive(VEC[i].rxc, VEC[i].txc, VEC[i].rde, VEC[i].sel, VEC[i].tim, 1'b0);
      #1;
      check($sformatf("R2 ok vec%0d", i), 64'(rx_ok), 64'(VEC[i].eok));
      if (VEC[i].eok)
        check($sformatf("R2 slot vec%0d", i), 64'(rx_slot), 64'(VEC[i].eslot));
      @(negedge clk);
      if (VEC[i].rde)
        check($sformatf("R9 data vec%0d", i), 64'(rd_data), 64'(VEC[i].edata));
      check($sformatf("R7 irq vec%0d", i), 64'(irq), 64'(VEC[i].eirq));
    end
    idle();

    // R3: overflow still sticky; R4: full slot kept its first value
    read_word(4'd0, d);
    check("R3 overflow sticky", 64'(d[5]), 64'd1);
    read_word(4'd15, d);
    check("R4 slot3 kept value", 64'(d), 64'hC0DE_0005);

    // R8: clear with a simultaneous receive strobe
    drive(1'b1, 1'b0, 1'b0, 4'd0, 16'h30, 1'b1);
    #1;
    check("R8 capture dropped on clear", 64'(rx_ok), 64'd0);
    @(negedge clk);
    idle();
    read_word(4'd0, d);
    check("R8 status cleared", 64'(d), 64'd0);

    // R7: enable low gives no interrupt
    irq_en = 1'b0;
    drive(1'b0, 1'b1, 1'b0, 4'd0, 16'h20, 1'b0);
    @(negedge clk);
    idle();
    check("R7 no irq when disabled", 64'(irq), 64'd0);
    read_word(4'd0, d);
    check("R7 tx held without irq", 64'(d), 64'h10);

    // R6: upper read and transmit capture in one cycle
    irq_en = 1'b1;
    drive(1'b0, 1'b1, 1'b1, 4'd3, 16'h21, 1'b0);
    @(negedge clk);
    idle();
    check("R6 read returns old", 64'(rd_data), 64'hC0DE_0020);
    check("R6 irq from new capture", 64'(irq), 64'd1);
    read_word(4'd2, d);
    check("R6 new value taken", 64'(d), 64'h5A5A_0021);

    // R5: lower read does not release
    read_word(4'd0, d);
    check("R5 tx still held", 64'(d), 64'h50);
    drive(1'b0, 1'b1, 1'b0, 4'd0, 16'h22, 1'b0);
    @(negedge clk);
    idle();
    read_word(4'd2, d);
    check("R5 held slot not replaced", 64'(d), 64'h5A5A_0021);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule